// File: doc/BRIEF.md
# Level-Interrupt End-of-Service Handler with Storm Throttling

This block sits beside the redirection table of a 24-input interrupt router and reacts to end-of-interrupt broadcasts coming back from the processors. A broadcast names a vector, a trigger mode and a flag saying the processor will retire level interrupts itself. On each accepted broadcast the block walks every table entry once, one pin per clock in ascending order. For each level entry carrying the broadcast vector it issues a strobe that clears that pin's remote-IRR bit. If the line is still asserted and unmasked, it also asks the delivery logic to send the interrupt again.

A guest that never quiets its device turns this into an endless loop of deliveries. Each pin therefore counts back-to-back immediate redeliveries. When a pin reaches the storm threshold, its counter restarts at zero and the redelivery is handed to a one-shot delay timer. When the timer expires, every level pin that is pending and not awaiting service is requested at once. The register interface and the delivery message are outside this block. It only consumes the table fields as flat vectors and produces per-pin strobes.

Top module: `eoi_storm_ctrl`

## Requirements
- R1: Only pins whose entry vector equals the broadcast vector and whose entry trigger mode is level (`pin_level` bit = 1) receive any strobe from a scan. All other pins see neither a clear nor a service strobe.
- R2: A broadcast with `eoi_level` = 0 (edge) or with `eoi_directed` = 1 produces no clear strobe and no service request.
- R3: An accepted broadcast holds `busy` high for exactly NPINS cycles. A processed pin gets one `rirr_clr` pulse. At most one pin is pulsed per cycle, in ascending pin order.
- R4: A processed pin that is unmasked (`pin_mask` bit = 0) with its `irr` bit set, and whose incremented count is below STORM_LIMIT, gets a `svc_req` pulse in the same cycle as its clear pulse.
- R5: A processed pin that is masked or no longer pending gets no service request, and its count returns to zero.
- R6: When the incremented count equals STORM_LIMIT, the pin gets no immediate request. Its count returns to zero and `defer_active` is raised.
- R7: The timer expires exactly DEFER_CYCLES cycles after `defer_active` rises. In that cycle `svc_req` pulses for every pin with `pin_level`=1, `irr`=1 and `remote_irr`=0, and `defer_active` falls.
- R8: A deferral raised while the timer is already running does not restart it.
- R9: Reset clears `busy`, `defer_active`, all strobes and every per-pin count, and cancels a pending deferral.
- R10: A broadcast presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eoi_valid | input | 1 | Broadcast present this cycle |
| eoi_vector | input | VEC_W | Broadcast vector |
| eoi_level | input | 1 | Broadcast trigger mode, 1 = level |
| eoi_directed | input | 1 | Processor retires level interrupts itself |
| pin_vector | input | NPINS*VEC_W | Entry vectors, pin i at bits i*VEC_W upward |
| pin_level | input | NPINS | Entry trigger mode per pin, 1 = level |
| pin_mask | input | NPINS | Entry mask per pin |
| irr | input | NPINS | Line pending per pin |
| remote_irr | input | NPINS | Awaiting end of service per pin |
| busy | output | 1 | Scan in progress |
| rirr_clr | output | NPINS | One-cycle remote-IRR clear strobe per pin |
| svc_req | output | NPINS | One-cycle delivery request per pin |
| defer_active | output | 1 | Deferred redelivery timer running |

## Verification
Broadcasts are tried against a table in which several pins share one vector. Those pins differ in mask, pending state and trigger mode, so matching, clearing and redelivery can each be told apart from the others. Edge and directed broadcasts, and a broadcast arriving during a scan, are each compared with a level broadcast on the same table to show they are inert. A long run of redeliveries to two pins on one vector shows several things. A masked step restarts the count, and reset clears it. The threshold step defers instead of servicing. Because the second pin hits the threshold two cycles after the first, the measured expiry delay shows whether the timer was restarted. The set of pins serviced at expiry follows the pending and remote-IRR state. A final reset cancels a deferral that is still pending.

// File: rtl/eoi_storm_ctrl.sv
module eoi_storm_ctrl #(
  parameter int NPINS        = 24,
  parameter int VEC_W        = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 2000000
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   eoi_valid,
  input  logic [VEC_W-1:0]       eoi_vector,
  input  logic                   eoi_level,
  input  logic                   eoi_directed,
  input  logic [NPINS*VEC_W-1:0] pin_vector,
  input  logic [NPINS-1:0]       pin_level,
  input  logic [NPINS-1:0]       pin_mask,
  input  logic [NPINS-1:0]       irr,
  input  logic [NPINS-1:0]       remote_irr,
  output logic                   busy,
  output logic [NPINS-1:0]       rirr_clr,
  output logic [NPINS-1:0]       svc_req,
  output logic                   defer_active
);
  localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int CNT_W = $clog2(STORM_LIMIT + 1);
  localparam int TMR_W = $clog2(DEFER_CYCLES + 1);

  logic             busy_q, act_q, tmr_on;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] vec_q;
  logic [TMR_W-1:0] tmr;
  logic [CNT_W-1:0] storm_cnt [NPINS];

  wire accept = eoi_valid & ~busy_q;
  wire [VEC_W-1:0] cur_vec = pin_vector[idx_q*VEC_W +: VEC_W];
  wire hit = busy_q & act_q & pin_level[idx_q] & (cur_vec == vec_q);
  wire refire = hit & ~pin_mask[idx_q] & irr[idx_q];
  wire [CNT_W-1:0] cnt_next = storm_cnt[idx_q] + CNT_W'(1);
  wire at_limit = refire & (cnt_next == CNT_W'(STORM_LIMIT));
  wire expire = tmr_on & (tmr == '0);

  assign busy = busy_q;
  assign defer_active = tmr_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      act_q  <= 1'b0;
      idx_q  <= '0;
      vec_q  <= '0;
    end else if (accept) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      vec_q  <= eoi_vector;
      act_q  <= eoi_level & ~eoi_directed;
    end else if (busy_q) begin
      if (idx_q == IDX_W'(NPINS - 1)) busy_q <= 1'b0;
      else idx_q <= idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rirr_clr <= '0;
      svc_req  <= '0;
    end else begin
      rirr_clr <= '0;
      svc_req  <= expire ? (pin_level & irr & ~remote_irr) : '0;
      if (hit) rirr_clr[idx_q] <= 1'b1;
      if (refire && !at_limit) svc_req[idx_q] <= 1'b1;
    end
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) storm_cnt[g] <= '0;
      else if (hit && idx_q == IDX_W'(g))
        storm_cnt[g] <= (refire && !at_limit) ? cnt_next : '0;
    end

    // R6
    cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      storm_cnt[g] < CNT_W'(STORM_LIMIT));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_on <= 1'b0;
      tmr    <= '0;
    end else if (tmr_on && tmr != '0) begin
      tmr <= tmr - TMR_W'(1);
    end else if (at_limit) begin
      tmr_on <= 1'b1;
      tmr    <= TMR_W'(DEFER_CYCLES - 1);
    end else begin
      tmr_on <= 1'b0;
    end
  end

  // R3
  one_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rirr_clr));

  // R3
  clr_in_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rirr_clr) |-> $past(busy_q));

  // R4
  svc_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|svc_req) |-> ($past(busy_q) || $past(tmr_on)));

  // R10
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && !busy_q) |=> busy_q);

  // R2
  passive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !act_q) |=> (rirr_clr == '0));
endmodule

// File: tb/eoi_storm_ctrl_tb.sv
module eoi_storm_ctrl_tb;
  localparam int NPINS = 24;
  localparam int VW = 8;
  localparam int LIM = 4;
  localparam int DLY = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic eoi_valid = 1'b0;
  logic [VW-1:0] eoi_vector = '0;
  logic eoi_level = 1'b1;
  logic eoi_directed = 1'b0;
  logic [NPINS*VW-1:0] pin_vector;
  logic [NPINS-1:0] pin_level, pin_mask, irr, remote_irr;
  logic busy, defer_active;
  logic [NPINS-1:0] rirr_clr, svc_req;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rise_cyc = -1;
  logic prev_def = 1'b0;
  logic [NPINS-1:0] acc_clr, acc_svc;
  int busy_n;
  bit order_ok;

  always #2.5 clk = ~clk;

  eoi_storm_ctrl #(.NPINS(NPINS), .VEC_W(VW), .STORM_LIMIT(LIM), .DEFER_CYCLES(DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .eoi_level(eoi_level), .eoi_directed(eoi_directed), .pin_vector(pin_vector),
    .pin_level(pin_level), .pin_mask(pin_mask), .irr(irr), .remote_irr(remote_irr),
    .busy(busy), .rirr_clr(rirr_clr), .svc_req(svc_req), .defer_active(defer_active));

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (defer_active && !prev_def) rise_cyc <= cyc;
    prev_def <= defer_active;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic table_init();
    for (int i = 0; i < NPINS; i++) pin_vector[i*VW +: VW] = VW'(8'h20 + i);
    pin_level = '1; pin_mask = '0; irr = '0; remote_irr = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 0 && defer_active == 0 && rirr_clr == 0 && svc_req == 0, "R9 reset state",
        {busy, defer_active, rirr_clr, svc_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic collect(input int n);
    int last = -1;
    acc_clr = '0; acc_svc = '0; busy_n = 0; order_ok = 1;
    for (int k = 0; k < n; k++) begin
      acc_clr |= rirr_clr; acc_svc |= svc_req;
      if (busy) busy_n++;
      for (int p = 0; p < NPINS; p++)
        if (rirr_clr[p]) begin
          if (p <= last) order_ok = 0;
          last = p;
        end
      @(negedge clk);
    end
  endtask

  task automatic eoi(input logic [VW-1:0] v, input logic lvl, input logic dir);
    @(negedge clk);
    eoi_valid = 1'b1; eoi_vector = v; eoi_level = lvl; eoi_directed = dir;
    @(negedge clk);
    eoi_valid = 1'b0;
    collect(NPINS + 3);
  endtask

  task automatic t_match();
    table_init();
    pin_vector[3*VW +: VW] = 8'h55; pin_vector[7*VW +: VW] = 8'h55; pin_vector[19*VW +: VW] = 8'h55;
    irr[3] = 1; irr[7] = 1; pin_mask[7] = 1; irr[5] = 1;
    eoi(8'h55, 1, 0);
    chk(acc_clr == 24'h080088, "R1 R3 clear set", acc_clr, 24'h080088);
    chk(acc_svc == 24'h000008, "R4 R5 service set", acc_svc, 24'h000008);
    chk(order_ok, "R3 ascending order", order_ok, 1);
    chk(busy_n == NPINS, "R3 busy length", busy_n, NPINS);
  endtask

  task automatic t_inert();
    eoi(8'h55, 0, 0);
    chk(acc_clr == 0 && acc_svc == 0, "R2 edge broadcast", {acc_clr, acc_svc}, 0);
    eoi(8'h55, 1, 1);
    chk(acc_clr == 0 && acc_svc == 0, "R2 directed broadcast", {acc_clr, acc_svc}, 0);
    pin_level[3] = 0;
    eoi(8'h55, 1, 0);
    chk(acc_clr == 24'h080080, "R1 edge entry skipped", acc_clr, 24'h080080);
    pin_level[3] = 1;
  endtask

  task automatic t_busy_ignore();
    irr[10] = 1;
    @(negedge clk);
    eoi_valid = 1; eoi_vector = 8'h55; eoi_level = 1; eoi_directed = 0;
    @(negedge clk);
    eoi_vector = 8'h2a;
    @(negedge clk);
    eoi_valid = 0;
    collect(NPINS + 3);
    chk(acc_clr == 24'h080088 && !acc_svc[10], "R10 broadcast during scan", acc_clr, 24'h080088);
    irr[10] = 0;
  endtask

  task automatic t_storm();
    int t0;
    table_init();
    pin_vector[2*VW +: VW] = 8'h60; pin_vector[4*VW +: VW] = 8'h60;
    irr[2] = 1; irr[4] = 1; irr[9] = 1; irr[11] = 1; remote_irr[11] = 1;
    irr[12] = 1; pin_level[12] = 0;
    do_reset();
    for (int i = 0; i < 3; i++) begin
      eoi(8'h60, 1, 0);
      chk(acc_svc == 24'h14 && acc_clr == 24'h14, "R4 immediate redelivery", acc_svc, 24'h14);
    end
    pin_mask[2] = 1; irr[4] = 0;
    eoi(8'h60, 1, 0);
    chk(acc_svc == 0 && acc_clr == 24'h14, "R5 masked or idle", acc_svc, 0);
    pin_mask[2] = 0; irr[4] = 1;
    for (int i = 0; i < 3; i++) begin
      eoi(8'h60, 1, 0);
      chk(acc_svc == 24'h14 && defer_active == 0, "R5 count restarted", acc_svc, 24'h14);
    end
    do_reset();
    for (int i = 0; i < 3; i++) begin
      eoi(8'h60, 1, 0);
      chk(acc_svc == 24'h14 && defer_active == 0, "R9 counts cleared", acc_svc, 24'h14);
    end
    eoi(8'h60, 1, 0);
    chk(acc_svc == 0 && acc_clr == 24'h14, "R6 threshold defers", acc_svc, 0);
    chk(defer_active == 1, "R6 timer started", defer_active, 1);
    t0 = -1;
    for (int k = 0; k < DLY + 20; k++) begin
      if (svc_req != 0) begin t0 = cyc; break; end
      @(negedge clk);
    end
    chk(t0 - rise_cyc == DLY, "R7 R8 expiry delay", t0 - rise_cyc, DLY);
    chk(svc_req == 24'h214, "R7 expiry service set", svc_req, 24'h214);
    chk(defer_active == 0, "R7 timer idle after expiry", defer_active, 0);
    eoi(8'h60, 1, 0);
    chk(acc_svc == 24'h14, "R6 count zero after threshold", acc_svc, 24'h14);
    eoi(8'h60, 1, 0);
    eoi(8'h60, 1, 0);
    eoi(8'h60, 1, 0);
    chk(defer_active == 1, "R6 second deferral", defer_active, 1);
    do_reset();
    collect(DLY + 10);
    chk(acc_svc == 0 && defer_active == 0, "R9 deferral cancelled", acc_svc, 0);
  endtask

  initial begin
    table_init();
    do_reset();
    t_match();
    t_inert();
    t_busy_ignore();
    t_storm();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule